// File: doc/BRIEF.md
# Eight-Bit Timer with Selectable Counter Clear

An 8-bit up-counter that steps once per count tick. The tick source is chosen from a control register. It can be one of three prescaled enables supplied from outside the block, or the rising, falling or both edges of an external clock pin. The counter is compared against two registers, A and B. It can be cleared by either compare match or by an external reset pin. That pin works either on its rising edge or, in level mode, holds the counter at zero while it stays high.

Software reaches the block through a simple register port. Reads return data one cycle after the read strobe. Three sticky event flags record compare match A, compare match B and counter overflow. A flag is cleared only by writing 0 to its bit after that bit has been read as 1. The overflow flag raises a registered interrupt when its enable bit is set. Both external pins pass through two-flop synchronisers before use.

Top module: `tick8_timer`

## Requirements
- R1: After reset, CTRL (address 0), STAT (address 1) and EXTM (address 5) read 0x00, CNT (address 2) reads 0x00, CMPA (address 3) and CMPB (address 4) read 0xFF, and `irq_ovf` is 0.
- R2: A write with `we` stores `wdata` into the addressed register. A read with `re` returns the addressed register on `rdata` after the next clock edge. CTRL holds the overflow interrupt enable at bit 5, the clear select at bits 4:3 and the clock select at bits 2:0; bits 7:6 read 0. EXTM bit 0 selects level mode. Unused addresses read 0.
- R3: The clock select picks the count tick as follows. 000 and 100 never tick. 001, 010 and 011 tick on `presc_en[0]`, `presc_en[1]` and `presc_en[2]`. 101, 110 and 111 tick on the rising, falling or both edges of `ext_clk`, after a two-flop synchroniser.
- R4: Each tick adds 1 to CNT. When a tick takes CNT from 0xFF to 0x00 by incrementing, STAT bit 2 (overflow) is set. No clear may take effect in that cycle.
- R5: A tick while CNT equals CMPA sets STAT bit 0. A tick while CNT equals CMPB sets STAT bit 1.
- R6: Clear select 00 never clears CNT. With 01, a tick while CNT equals CMPA loads 0x00 instead of the increment. With 10, the same happens for CMPB.
- R7: Clear select 11 with EXTM bit 0 = 0 clears CNT once on each synchronised rising edge of `ext_rst`, without needing a tick. Later ticks count normally while the pin stays high.
- R8: Clear select 11 with EXTM bit 0 = 1 holds CNT at 0x00 for as long as the synchronised `ext_rst` is high, whatever the ticks do. Counting resumes once the pin falls.
- R9: When the clear select is not 11, `ext_rst` has no effect on CNT.
- R10: A write to CNT wins over a tick and over any clear in the same cycle. That tick sets no flag.
- R11: Writing 0 to a STAT bit clears it only if the bit has been read as 1 since it was last set. Writing 1 to a STAT bit has no effect. A hardware set wins over a clear in the same cycle.
- R12: `irq_ovf` is a register that equals (STAT bit 2 AND CTRL bit 5) as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| presc_en | input | 3 | Prescaled count enables (divide by 8, 64, 8192) |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| ext_rst | input | 1 | External counter reset pin, asynchronous |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `presc_en` pulses are single-cycle, synchronous enables. They also assume that the pins hold each level long enough to cross the two synchroniser stages, and that software never writes CNT and STAT in the same cycle. The bench makes every tick a one-cycle pulse driven between edges. It holds each level on `ext_clk` and `ext_rst` for at least four cycles. It issues one register access at a time, so every expected count and flag can be computed tick by tick in the bench.

// File: rtl/tick8_pkg.sv
package tick8_pkg;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] RA_CTRL = 3'd0;
  localparam logic [AW-1:0] RA_STAT = 3'd1;
  localparam logic [AW-1:0] RA_CNT  = 3'd2;
  localparam logic [AW-1:0] RA_CMPA = 3'd3;
  localparam logic [AW-1:0] RA_CMPB = 3'd4;
  localparam logic [AW-1:0] RA_EXTM = 3'd5;

  localparam int unsigned IE_BIT   = 5;
  localparam int unsigned CLR_LSB  = 3;
  localparam int unsigned CKS_LSB  = 0;
  localparam int unsigned CKS_W    = 3;
  localparam int unsigned NFLAG    = 3;
  localparam int unsigned F_CMA    = 0;
  localparam int unsigned F_CMB    = 1;
  localparam int unsigned F_OVF    = 2;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMPA = 2'b01,
    CLR_CMPB = 2'b10,
    CLR_EXT  = 2'b11
  } clr_sel_e;
endpackage

// File: rtl/tick8_sync.sv
module tick8_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tick8_clksel.sv
module tick8_clksel
  import tick8_pkg::*;
#(
  parameter int unsigned NPRE = 3
) (
  input  logic [CKS_W-1:0] cks,
  input  logic [NPRE-1:0]  presc_en,
  input  logic             xc_rise,
  input  logic             xc_fall,
  output logic             tick
);
  always_comb begin
    tick = 1'b0;
    case (cks)
      3'b101: tick = xc_rise;
      3'b110: tick = xc_fall;
      3'b111: tick = xc_rise | xc_fall;
      default: begin
        for (int i = 0; i < NPRE; i++) begin
          if (cks == CKS_W'(i + 1)) tick = presc_en[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/tick8_counter.sv
module tick8_counter
  import tick8_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  clr_sel_e      cclr,
  input  logic          lvl_mode,
  input  logic          xr_lvl,
  input  logic          xr_rise,
  input  logic [CW-1:0] cmpa,
  input  logic [CW-1:0] cmpb,
  input  logic          wr,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] cnt,
  output logic          hit_a,
  output logic          hit_b,
  output logic          ovf_ev
);
  localparam logic [CW-1:0] TOP = '1;

  logic eff_tick, clr_ext, clr_match;

  assign eff_tick  = tick & ~wr;
  assign clr_ext   = (cclr == CLR_EXT) & (lvl_mode ? xr_lvl : xr_rise);
  assign hit_a     = eff_tick & (cnt == cmpa);
  assign hit_b     = eff_tick & (cnt == cmpb);
  assign clr_match = ((cclr == CLR_CMPA) & hit_a) | ((cclr == CLR_CMPB) & hit_b);
  assign ovf_ev    = eff_tick & (cnt == TOP) & ~clr_match & ~clr_ext;

  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (wr)                     cnt <= wr_val;
    else if (clr_ext || clr_match)   cnt <= '0;
    else if (eff_tick)               cnt <= cnt + 1'b1;
  end

  AST_CLR_ON_A: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr && cclr == CLR_CMPA && cnt == cmpa) |=> cnt == '0); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr && cclr == CLR_EXT && lvl_mode && xr_lvl) |=> cnt == '0); // R8
  AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt == $past(wr_val)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr && cclr != CLR_EXT) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tick8_timer.sv
module tick8_timer
  import tick8_pkg::*;
#(
  parameter int unsigned CW   = 8,
  parameter int unsigned NPRE = 3,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [NPRE-1:0] presc_en,
  input  logic          ext_clk,
  input  logic          ext_rst,
  output logic          irq_ovf
);
  logic [CKS_W-1:0] cks_q;
  clr_sel_e         cclr_q;
  logic             ie_q, lvl_q;
  logic [CW-1:0]    cmpa_q, cmpb_q, cnt;
  logic [NFLAG-1:0] flag_q, arm_q, flag_set, flag_clr;
  logic             xc_lvl, xc_rise, xc_fall, xr_lvl, xr_rise, xr_fall;
  logic             tick, hit_a, hit_b, ovf_ev, wr_cnt, wr_stat, rd_stat;

  tick8_sync #(.STAGES(SYNC)) u_sclk (
    .clk(clk), .rst(rst), .pin(ext_clk), .lvl(xc_lvl), .rise(xc_rise), .fall(xc_fall));
  tick8_sync #(.STAGES(SYNC)) u_srst (
    .clk(clk), .rst(rst), .pin(ext_rst), .lvl(xr_lvl), .rise(xr_rise), .fall(xr_fall));

  tick8_clksel #(.NPRE(NPRE)) u_sel (
    .cks(cks_q), .presc_en(presc_en), .xc_rise(xc_rise), .xc_fall(xc_fall), .tick(tick));

  assign wr_cnt  = we & (addr == RA_CNT);
  assign wr_stat = we & (addr == RA_STAT);
  assign rd_stat = re & (addr == RA_STAT);

  tick8_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cclr(cclr_q), .lvl_mode(lvl_q),
    .xr_lvl(xr_lvl), .xr_rise(xr_rise), .cmpa(cmpa_q), .cmpb(cmpb_q),
    .wr(wr_cnt), .wr_val(wdata), .cnt(cnt),
    .hit_a(hit_a), .hit_b(hit_b), .ovf_ev(ovf_ev));

  always_ff @(posedge clk) begin
    if (rst) begin
      cks_q  <= '0;
      cclr_q <= CLR_NONE;
      ie_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cmpa_q <= '1;
      cmpb_q <= '1;
    end else if (we) begin
      case (addr)
        RA_CTRL: begin
          cks_q  <= wdata[CKS_LSB +: CKS_W];
          cclr_q <= clr_sel_e'(wdata[CLR_LSB +: 2]);
          ie_q   <= wdata[IE_BIT];
        end
        RA_CMPA: cmpa_q <= wdata;
        RA_CMPB: cmpb_q <= wdata;
        RA_EXTM: lvl_q  <= wdata[0];
        default: ;
      endcase
    end
  end

  assign flag_set = {ovf_ev, hit_b, hit_a};

  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      assign flag_clr[g] = wr_stat & ~wdata[g] & arm_q[g];
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q[g] <= 1'b0;
          arm_q[g]  <= 1'b0;
        end else begin
          flag_q[g] <= flag_set[g] | (flag_q[g] & ~flag_clr[g]);
          if (flag_clr[g])                arm_q[g] <= 1'b0;
          else if (rd_stat && flag_q[g])  arm_q[g] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_ovf <= 1'b0;
    end else begin
      irq_ovf <= flag_q[F_OVF] & ie_q;
      if (re) begin
        case (addr)
          RA_CTRL: rdata <= CW'({ie_q, cclr_q, cks_q});
          RA_STAT: rdata <= CW'(flag_q);
          RA_CNT:  rdata <= cnt;
          RA_CMPA: rdata <= cmpa_q;
          RA_CMPB: rdata <= cmpb_q;
          RA_EXTM: rdata <= CW'(lvl_q);
          default: rdata <= '0;
        endcase
      end
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> $past(ie_q)); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q[F_OVF] && !wr_stat) |=> flag_q[F_OVF]); // R11
  AST_NO_SPURIOUS_ARM: assert property (@(posedge clk) disable iff (rst)
    (!flag_q[F_OVF] && !flag_set[F_OVF]) |=> !flag_q[F_OVF]); // R4
endmodule

// File: tb/sim_tick8_timer.sv
`timescale 1ns/1ps
module sim_tick8_timer;
  logic       clk = 1'b0;
  logic       rst, we, re, ext_clk, ext_rst;
  logic [2:0] addr, presc_en;
  logic [7:0] wdata, rdata;
  logic       irq_ovf;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_cnt, m_cmpa, m_cmpb;
  logic [2:0] m_flag;
  logic [1:0] m_clr;
  logic       m_ie;

  always #2 clk = ~clk;

  tick8_timer u0 (.clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wdata(wdata),
    .rdata(rdata), .presc_en(presc_en), .ext_clk(ext_clk), .ext_rst(ext_rst), .irq_ovf(irq_ovf));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0; d = rdata;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); presc_en[k] = 1;
    @(negedge clk); presc_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void model_tick();
    logic clr;
    if (m_cnt == m_cmpa) m_flag[0] = 1;
    if (m_cnt == m_cmpb) m_flag[1] = 1;
    clr = (m_clr == 2'd1 && m_cnt == m_cmpa) || (m_clr == 2'd2 && m_cnt == m_cmpb);
    if (clr) m_cnt = 0;
    else begin
      if (m_cnt == 8'hFF) m_flag[2] = 1;
      m_cnt = m_cnt + 1;
    end
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    rst = 1; we = 0; re = 0; addr = 0; wdata = 0; presc_en = 0; ext_clk = 0; ext_rst = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rd(3'd0, d); check("R1 CTRL", d, 8'h00);
    rd(3'd1, d); check("R1 STAT", d, 8'h00);
    rd(3'd2, d); check("R1 CNT", d, 8'h00);
    rd(3'd3, d); check("R1 CMPA", d, 8'hFF);
    rd(3'd4, d); check("R1 CMPB", d, 8'hFF);
    rd(3'd5, d); check("R1 EXTM", d, 8'h00);
    check("R1 irq", {7'd0, irq_ovf}, 8'h00);

    // R2 readback
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 CTRL mask", d, 8'h3F);
    wr(3'd0, 8'h00); rd(3'd6, d); check("R2 unused", d, 8'h00);
    wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    rd(3'd3, d); check("R2 CMPA", d, 8'h80);

    // R3 stopped clock and prescaler selection
    pulse(0); pulse(1); rd(3'd2, d); check("R3 cks000 stop", d, 8'h00);
    wr(3'd0, 8'h02); pulse(0); rd(3'd2, d); check("R3 cks010 ignores en0", d, 8'h00);
    pulse(1); pulse(1); rd(3'd2, d); check("R3 cks010 counts en1", d, 8'h02);
    wr(3'd0, 8'h03); pulse(2); rd(3'd2, d); check("R3 cks011 en2", d, 8'h03);
    wr(3'd0, 8'h04); pulse(0); pulse(2); rd(3'd2, d); check("R3 cks100 stop", d, 8'h03);
    // external clock edges
    wr(3'd0, 8'h05); ext_clk = 1; idle(4); ext_clk = 0; idle(4);
    rd(3'd2, d); check("R3 ext rise", d, 8'h04);
    wr(3'd0, 8'h06); ext_clk = 1; idle(4); rd(3'd2, d); check("R3 fall ignores rise", d, 8'h04);
    ext_clk = 0; idle(4); rd(3'd2, d); check("R3 ext fall", d, 8'h05);
    wr(3'd0, 8'h07); ext_clk = 1; idle(4); ext_clk = 0; idle(4);
    rd(3'd2, d); check("R3 ext both", d, 8'h07);

    // R4 overflow, R11 flag clearing, R12 irq
    wr(3'd0, 8'h01); wr(3'd2, 8'hFF); pulse(0);
    rd(3'd2, d); check("R4 wrap", d, 8'h00);
    wr(3'd1, 8'h00); rd(3'd1, d); check("R11 unarmed write 0", d, 8'h04);
    check("R12 irq masked", {7'd0, irq_ovf}, 8'h00);
    wr(3'd0, 8'h21); idle(2); check("R12 irq enabled", {7'd0, irq_ovf}, 8'h01);
    wr(3'd1, 8'hFF); rd(3'd1, d); check("R11 write 1 no effect", d, 8'h04);
    wr(3'd1, 8'h00); rd(3'd1, d); check("R11 armed clear", d, 8'h00);
    idle(2); check("R12 irq drops", {7'd0, irq_ovf}, 8'h00);

    // R5/R6 compare A and B clears
    wr(3'd0, 8'h09); wr(3'd3, 8'h05); wr(3'd2, 8'h05); pulse(0);
    rd(3'd2, d); check("R6 clear on A", d, 8'h00);
    rd(3'd1, d); check("R5 flag A", d, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h11); wr(3'd4, 8'h07); wr(3'd2, 8'h07); pulse(0);
    rd(3'd2, d); check("R6 clear on B", d, 8'h00);
    rd(3'd1, d); check("R5 flag B", d, 8'h02);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h01); wr(3'd2, 8'h05); pulse(0);
    rd(3'd2, d); check("R6 no clear sel 00", d, 8'h06);

    // R10 write beats tick and clear
    wr(3'd0, 8'h09); wr(3'd1, 8'h00); wr(3'd2, 8'h05);
    @(negedge clk); we = 1; addr = 3'd2; wdata = 8'h33; presc_en[0] = 1;
    @(negedge clk); we = 0; presc_en = 0;
    rd(3'd2, d); check("R10 write wins", d, 8'h33);
    rd(3'd1, d); check("R10 no flag", d, 8'h01);
    wr(3'd1, 8'h00);

    // R7 edge mode
    wr(3'd0, 8'h19); wr(3'd5, 8'h00); wr(3'd2, 8'h40);
    ext_rst = 1; idle(5); rd(3'd2, d); check("R7 edge clear", d, 8'h00);
    pulse(0); rd(3'd2, d); check("R7 counts while high", d, 8'h01);
    ext_rst = 0; idle(5);
    // R8 level mode
    wr(3'd5, 8'h01); wr(3'd2, 8'h40); ext_rst = 1; idle(5);
    pulse(0); pulse(0); rd(3'd2, d); check("R8 held clear", d, 8'h00);
    ext_rst = 0; idle(5); pulse(0); rd(3'd2, d); check("R8 release", d, 8'h01);
    // R9 ignored when not ext clear
    wr(3'd0, 8'h01); wr(3'd2, 8'h10); ext_rst = 1; idle(5);
    rd(3'd2, d); check("R9 ignored", d, 8'h10);
    ext_rst = 0; idle(5); wr(3'd5, 8'h00);

    // random phase against model (R4 R5 R6 R11 R12)
    rd(3'd1, d); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    m_cnt = 0; m_flag = 0;
    for (int it = 0; it < 150; it++) begin
      m_clr = 2'($urandom % 3); m_ie = 1'($urandom % 2);
      m_cmpa = 8'($urandom % 48); m_cmpb = 8'($urandom % 48);
      if (it % 10 == 0) begin m_cnt = 8'hF0 + 8'($urandom % 16); wr(3'd2, m_cnt); end
      wr(3'd0, {2'b00, m_ie, m_clr, 3'b001}); wr(3'd3, m_cmpa); wr(3'd4, m_cmpb);
      for (int t = 0; t < int'($urandom % 40); t++) begin
        pulse(0); model_tick();
        if ($urandom % 3 == 0) idle(1);
      end
      rd(3'd2, d); check("R6 random count", d, m_cnt);
      rd(3'd1, d); check("R5 random flags", d, {5'd0, m_flag});
      check("R12 random irq", {7'd0, irq_ovf}, {7'd0, m_flag[2] & m_ie});
      if ($urandom % 2 == 0) begin wr(3'd1, 8'h00); m_flag = 0; end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule